// File: doc/BRIEF.md
# Thread Context Ring Match Unit

This unit takes a notification target and works out which privilege ring of one hardware thread's interrupt context claims it. A thread context holds four rings: physical, pool, OS and user. The target arrives as a block number, an index, a format bit, an ignore bit and a logical server number. The unit joins the block and index into one virtual-processor line and compares that line against what each ring holds.

Most targets use format 0. For these the physical, pool and OS rings are tested in that order, and the first ring that matches is reported. The physical ring keeps no line of its own. Its line is built from the configured block id and a thread field made from the configured thread id, at a thread-id width of 7 or 8 bits. Format 1 targets only the user ring. A user match needs the OS ring to match as well, together with equal logical server numbers.

The result is one registered stage. It is a match flag and a 2-bit ring code, and both appear one clock after the inputs.

Top module: `ring_match_unit`

## Requirements
- R1: The compare line is the target block in the upper BLK_W bits joined to the target index in the lower IDX_W bits. A target whose block differs from the configured block id never matches the physical ring.
- R2: With format 0 and the ignore bit set, the result is no match, whatever the ring contents are.
- R3: With format 0 and the ignore bit clear, the rings are tested in the order physical, pool, OS, and only the first matching ring is reported.
- R4: The physical ring matches when its valid bit is set and the compare line equals the hardware line. The hardware line is the configured block id over a thread field of (1 << w) | (thread_id & ((1 << w) - 1)), zero-extended to IDX_W bits.
- R5: The width w is 7 when cfgTidWide is 0 and 8 when cfgTidWide is 1. A hardware line built with the other width does not match.
- R6: The pool ring and the OS ring each match when their own valid bit is set and their stored line equals the compare line.
- R7: With format 1, only the user ring can match. A user match needs osValid set, osLine equal to the compare line, userValid set and userServ equal to tgtServ. The physical and pool rings are ignored.
- R8: When nothing matches, matchValid is 0 and ringCode is 0.
- R9: The ring codes are user = 0, OS = 1, pool = 2 and physical = 3.
- R10: The result is registered. It reflects the inputs sampled at the previous rising clock edge, and reset clears matchValid and ringCode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 1 | Target format: 0 selects specific rings, 1 selects the user ring |
| ignoreLow | input | 1 | Ignore bit; in format 0 it makes the request unsupported |
| tgtBlk | input | BLK_W | Target block |
| tgtIdx | input | IDX_W | Target index |
| tgtServ | input | SERV_W | Requested logical server number |
| cfgBlk | input | BLK_W | Configured block id of this thread |
| cfgTid | input | TID_W | Configured thread id |
| cfgTidWide | input | 1 | Thread-id width select: 0 gives 7 bits, 1 gives 8 bits |
| physValid | input | 1 | Physical ring valid |
| poolValid | input | 1 | Pool ring valid |
| poolLine | input | BLK_W+IDX_W | Line stored in the pool ring |
| osValid | input | 1 | OS ring valid |
| osLine | input | BLK_W+IDX_W | Line stored in the OS ring |
| userValid | input | 1 | User ring valid |
| userServ | input | SERV_W | Logical server number stored in the user ring |
| matchValid | output | 1 | A ring matched |
| ringCode | output | 2 | Ring that matched |

## Verification
The result passes through a single register, so any error shows up on matchValid or ringCode exactly one clock after the stimulus that causes it. A wrong priority order shows up as the wrong ring code whenever two or more rings hit together. A bad hardware-line build shows up as a physical hit missing, or as a spurious physical hit, when the target is built with the other thread-id width. A broken format gate shows up as a physical or pool code reported for a format 1 target, or as a user match that has no OS match behind it.

// File: rtl/ring_match_pkg.sv
package ring_match_pkg;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_code_e;

  // raw compare results, datapath -> control
  typedef struct packed {
    logic physEq;
    logic poolEq;
    logic osEq;
    logic servEq;
  } ring_eq_t;

  // selection strobes, control -> datapath
  typedef struct packed {
    logic pickPhys;
    logic pickPool;
    logic pickOs;
    logic pickUser;
  } ring_pick_t;

endpackage

// File: rtl/ring_match_ctrl.sv
module ring_match_ctrl
  import ring_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fmtSel,
  input  logic       ignoreLow,
  input  logic       physValid,
  input  logic       poolValid,
  input  logic       osValid,
  input  logic       userValid,
  input  ring_eq_t   eqIn,
  output ring_pick_t pickOut
);

  logic specificMode;
  logic userMode;

  assign specificMode = !fmtSel && !ignoreLow;
  assign userMode     = fmtSel;

  always_comb begin
    pickOut = '0;
    pickOut.pickPhys = specificMode && physValid && eqIn.physEq;
    pickOut.pickPool = specificMode && !pickOut.pickPhys && poolValid && eqIn.poolEq;
    pickOut.pickOs   = specificMode && !pickOut.pickPhys && !pickOut.pickPool
                       && osValid && eqIn.osEq;
    pickOut.pickUser = userMode && osValid && eqIn.osEq && userValid && eqIn.servEq;
  end

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pickOut)); // R3

  AST_IGNORE_NO_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (!fmtSel && ignoreLow) |-> (pickOut == '0)); // R2

endmodule

// File: rtl/ring_match_dp.sv
module ring_match_dp
  import ring_match_pkg::*;
#(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 12,
  parameter int TID_W  = 8,
  parameter int SERV_W = 8,
  localparam int LINE_W = BLK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fmtSel,
  input  logic              ignoreLow,
  input  logic [BLK_W-1:0]  tgtBlk,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [SERV_W-1:0] tgtServ,
  input  logic [BLK_W-1:0]  cfgBlk,
  input  logic [TID_W-1:0]  cfgTid,
  input  logic              cfgTidWide,
  input  logic              physValid,
  input  logic              poolValid,
  input  logic [LINE_W-1:0] poolLine,
  input  logic              osValid,
  input  logic [LINE_W-1:0] osLine,
  input  logic              userValid,
  input  logic [SERV_W-1:0] userServ,
  input  ring_pick_t        pickIn,
  output ring_eq_t          eqOut,
  output logic              matchValid,
  output logic [1:0]        ringCode
);

  localparam int NUM_STORED = 2;

  logic [LINE_W-1:0] cmpLine;
  logic [IDX_W-1:0]  hwThread;
  logic [LINE_W-1:0] hwLine;
  logic [LINE_W-1:0] storedLine [NUM_STORED];
  logic [NUM_STORED-1:0] storedEq;

  assign cmpLine = {tgtBlk, tgtIdx};

  // thread field: marker bit above the thread id, masked to the chosen width
  always_comb begin
    hwThread = '0;
    if (cfgTidWide) begin
      hwThread[TID_W]     = 1'b1;
      hwThread[TID_W-1:0] = cfgTid;
    end else begin
      hwThread[TID_W-1]   = 1'b1;
      hwThread[TID_W-2:0] = cfgTid[TID_W-2:0];
    end
  end

  assign hwLine = {cfgBlk, hwThread};

  assign storedLine[0] = poolLine;
  assign storedLine[1] = osLine;

  for (genvar g = 0; g < NUM_STORED; g++) begin : g_lineCmp
    assign storedEq[g] = (storedLine[g] == cmpLine);
  end

  assign eqOut.physEq = (hwLine == cmpLine);
  assign eqOut.poolEq = storedEq[0];
  assign eqOut.osEq   = storedEq[1];
  assign eqOut.servEq = (userServ == tgtServ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      ringCode   <= 2'd0;
    end else begin
      matchValid <= |pickIn;
      if (pickIn.pickPhys)      ringCode <= RING_PHYS;
      else if (pickIn.pickPool) ringCode <= RING_POOL;
      else if (pickIn.pickOs)   ringCode <= RING_OS;
      else                      ringCode <= RING_USER;
    end
  end

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !matchValid |-> (ringCode == 2'd0)); // R8

  AST_FMT1_USER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && $past(fmtSel)) |-> (ringCode == RING_USER)); // R7

  AST_USER_NEEDS_OS: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && ringCode == RING_USER)
      |-> $past(osValid && userValid && eqOut.osEq && eqOut.servEq)); // R7

  AST_POOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && ringCode == RING_POOL) |-> $past(poolValid && eqOut.poolEq)); // R6

  AST_PHYS_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!fmtSel && !ignoreLow && physValid && eqOut.physEq))
      |-> (matchValid && ringCode == RING_PHYS)); // R3

  AST_PICK_TO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(pickIn != '0)) |-> matchValid); // R10

endmodule

// File: rtl/ring_match_unit.sv
module ring_match_unit
  import ring_match_pkg::*;
#(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 12,
  parameter int TID_W  = 8,
  parameter int SERV_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fmtSel,
  input  logic                    ignoreLow,
  input  logic [BLK_W-1:0]        tgtBlk,
  input  logic [IDX_W-1:0]        tgtIdx,
  input  logic [SERV_W-1:0]       tgtServ,
  input  logic [BLK_W-1:0]        cfgBlk,
  input  logic [TID_W-1:0]        cfgTid,
  input  logic                    cfgTidWide,
  input  logic                    physValid,
  input  logic                    poolValid,
  input  logic [BLK_W+IDX_W-1:0]  poolLine,
  input  logic                    osValid,
  input  logic [BLK_W+IDX_W-1:0]  osLine,
  input  logic                    userValid,
  input  logic [SERV_W-1:0]       userServ,
  output logic                    matchValid,
  output logic [1:0]              ringCode
);

  ring_eq_t   eqBus;
  ring_pick_t pickBus;

  ring_match_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fmtSel    (fmtSel),
    .ignoreLow (ignoreLow),
    .physValid (physValid),
    .poolValid (poolValid),
    .osValid   (osValid),
    .userValid (userValid),
    .eqIn      (eqBus),
    .pickOut   (pickBus)
  );

  ring_match_dp #(
    .BLK_W  (BLK_W),
    .IDX_W  (IDX_W),
    .TID_W  (TID_W),
    .SERV_W (SERV_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fmtSel     (fmtSel),
    .ignoreLow  (ignoreLow),
    .tgtBlk     (tgtBlk),
    .tgtIdx     (tgtIdx),
    .tgtServ    (tgtServ),
    .cfgBlk     (cfgBlk),
    .cfgTid     (cfgTid),
    .cfgTidWide (cfgTidWide),
    .physValid  (physValid),
    .poolValid  (poolValid),
    .poolLine   (poolLine),
    .osValid    (osValid),
    .osLine     (osLine),
    .userValid  (userValid),
    .userServ   (userServ),
    .pickIn     (pickBus),
    .eqOut      (eqBus),
    .matchValid (matchValid),
    .ringCode   (ringCode)
  );

endmodule

// File: tb/ring_match_unit_tb.sv
module ring_match_unit_tb;

  localparam int BLK_W  = 4;
  localparam int IDX_W  = 12;
  localparam int TID_W  = 8;
  localparam int SERV_W = 8;
  localparam int LINE_W = BLK_W + IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fmtSel = 1'b0;
  logic              ignoreLow = 1'b0;
  logic [BLK_W-1:0]  tgtBlk = '0;
  logic [IDX_W-1:0]  tgtIdx = '0;
  logic [SERV_W-1:0] tgtServ = '0;
  logic [BLK_W-1:0]  cfgBlk = '0;
  logic [TID_W-1:0]  cfgTid = '0;
  logic              cfgTidWide = 1'b0;
  logic              physValid = 1'b0;
  logic              poolValid = 1'b0;
  logic [LINE_W-1:0] poolLine = '0;
  logic              osValid = 1'b0;
  logic [LINE_W-1:0] osLine = '0;
  logic              userValid = 1'b0;
  logic [SERV_W-1:0] userServ = '0;
  logic              matchValid;
  logic [1:0]        ringCode;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ring_match_unit #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W), .SERV_W(SERV_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .ignoreLow(ignoreLow),
    .tgtBlk(tgtBlk), .tgtIdx(tgtIdx), .tgtServ(tgtServ),
    .cfgBlk(cfgBlk), .cfgTid(cfgTid), .cfgTidWide(cfgTidWide),
    .physValid(physValid), .poolValid(poolValid), .poolLine(poolLine),
    .osValid(osValid), .osLine(osLine), .userValid(userValid),
    .userServ(userServ), .matchValid(matchValid), .ringCode(ringCode)
  );

  // hardware line per R4/R5
  function automatic logic [LINE_W-1:0] hwLineOf(input logic [BLK_W-1:0] blk,
                                                 input logic [TID_W-1:0] tid,
                                                 input logic wide);
    int w;
    int fieldVal;
    w = wide ? 8 : 7;
    fieldVal = (1 << w) | (int'(tid) & ((1 << w) - 1));
    return {blk, IDX_W'(fieldVal)};
  endfunction

  task automatic checkOut(input logic expV, input logic [1:0] expC, input string tag);
    total++;
    if (matchValid !== expV || ringCode !== expC) begin
      bad++;
      $display("FAIL %s: got valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, matchValid, ringCode, expV, expC);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    finishRun();
  end

  initial begin
    logic [LINE_W-1:0] cmp;
    logic expV;
    logic [1:0] expC;
    string tag;

    // reset state (R10)
    repeat (3) @(negedge clk);
    checkOut(1'b0, 2'd0, "R10 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 2'd0, "R10 after reset");

    cfgBlk = 4'h3;

    // sweep over format, ignore, valids, line equalities, width and target kind
    for (int tidSel = 0; tidSel < 2; tidSel++) begin
      for (int wide = 0; wide < 2; wide++) begin
        for (int tmode = 0; tmode < 3; tmode++) begin
          for (int f = 0; f < 2; f++) begin
            for (int ig = 0; ig < 2; ig++) begin
              for (int vv = 0; vv < 16; vv++) begin
                for (int eqs = 0; eqs < 8; eqs++) begin
                  cfgTid     = (tidSel == 0) ? 8'h45 : 8'hC5;
                  cfgTidWide = wide[0];
                  if (tmode == 0)      cmp = hwLineOf(cfgBlk, cfgTid, wide[0]);
                  else if (tmode == 1) cmp = hwLineOf(cfgBlk, cfgTid, !wide[0]);
                  else                 cmp = {4'h3, 12'h2A5};
                  fmtSel    = f[0];
                  ignoreLow = ig[0];
                  {tgtBlk, tgtIdx} = cmp;   // R1: compare line = {block, index}
                  tgtServ   = 8'h5A;
                  physValid = vv[3];
                  poolValid = vv[2];
                  osValid   = vv[1];
                  userValid = vv[0];
                  poolLine  = eqs[2] ? cmp : (cmp ^ 16'h0001);
                  osLine    = eqs[1] ? cmp : (cmp ^ 16'h0010);
                  userServ  = eqs[0] ? tgtServ : (tgtServ ^ 8'h01);

                  expV = 1'b0; expC = 2'd0; tag = "R8 none";
                  if (f == 1) begin
                    tag = "R7 R9 user";
                    if (vv[1] && eqs[1] && vv[0] && eqs[0]) begin
                      expV = 1'b1; expC = 2'd0;
                    end
                  end else if (ig == 1) begin
                    tag = "R2 ignore";
                  end else if (vv[3] && tmode == 0) begin
                    expV = 1'b1; expC = 2'd3; tag = "R3 R4 R5 R9 phys";
                  end else if (vv[2] && eqs[2]) begin
                    expV = 1'b1; expC = 2'd2; tag = "R3 R6 R9 pool";
                  end else if (vv[1] && eqs[1]) begin
                    expV = 1'b1; expC = 2'd1; tag = "R3 R6 R9 os";
                  end else if (vv[3] && tmode == 1) begin
                    tag = "R5 R8 wrong width";
                  end
                  @(negedge clk);   // one register: result after the next edge (R10)
                  checkOut(expV, expC, tag);
                end
              end
            end
          end
        end
      end
    end

    // R1: same index as hardware line but a different block gives no physical hit
    fmtSel = 1'b0; ignoreLow = 1'b0;
    physValid = 1'b1; poolValid = 1'b0; osValid = 1'b0; userValid = 1'b0;
    cfgTid = 8'h45; cfgTidWide = 1'b1;
    cmp = hwLineOf(cfgBlk, cfgTid, 1'b1);
    tgtBlk = 4'h9; tgtIdx = cmp[IDX_W-1:0];
    @(negedge clk);
    checkOut(1'b0, 2'd0, "R1 block mismatch");

    // R10: output holds until the next rising edge
    tgtBlk = cfgBlk;
    #1;
    checkOut(1'b0, 2'd0, "R10 before edge");
    @(negedge clk);
    checkOut(1'b1, 2'd3, "R10 after edge");

    // R10: reset clears a live match
    rstN = 1'b0;
    @(negedge clk);
    checkOut(1'b0, 2'd0, "R10 reset clears");

    finishRun();
  end

endmodule